// File: doc/BRIEF.md
# ADC Sequencer and Trigger Controller

This block is the digital control logic that sits around an analog-to-digital converter cell. Software reaches it through a small 32-bit register interface. Through that interface it powers the block up and down, picks the converter clock ratio and the conversion trigger, and reads back the last result, the status flags and the interrupt mask. A conversion can be started by a software pulse, by an internal reload interval timer, by a free-running continuous sequencer, or by an edge on an external trigger pin. The block divides its input clock by a power of two to form the converter clock. It can hold off the enabled indication for a programmed number of converter clocks after power-up.

The converter cell itself is outside the block. Each conversion is a handshake: a one-cycle `conv_start` pulse goes out together with the selected channel numbers, and the cell answers later with a one-cycle `conv_done` and a 12-bit sample. The block formats the sample, stores it with its channel numbers and updates the event flags. A single interrupt line is raised when any flag is set whose mask bit is also set.

Top module: `adc_seq_ctrl`

Register map. All offsets are byte offsets and every access is a full 32-bit word. Writes are accepted only when address bits 1:0 are zero.

| Offset | Access | Content |
|---|---|---|
| 0x00 | write-only | control pulses: bit 0 soft reset, bit 1 timer stop, bit 2 timer start, bit 3 software trigger, bit 8 power-up, bit 9 power-down |
| 0x04 | read/write | bits 10:8 clock ratio select N |
| 0x08 | read-only | status |
| 0x0C | write-only | status clear (write 1 to clear) |
| 0x10 | read/write | sequencer: bit 0 left-adjust, bits 10:8 trigger source, bit 12 8-bit mode, bits 19:16 positive channel, bits 22:20 negative channel |
| 0x14 | read/write | bit 8 startup delay on, bits 4:0 startup count |
| 0x18 | read/write | bits 15:0 interval timer maximum count |
| 0x1C | read-only | last result |
| 0x20 | write-only | interrupt mask set |
| 0x24 | write-only | interrupt mask clear |
| 0x28 | read-only | interrupt mask |

## Requirements
- R1: After reset, the status, last-result and interrupt-mask registers read as zero, and `irq` and `conv_start` are low.
- R2: The converter clock is the input clock divided by 2^(N+2), where N is configuration bits 10:8. N=0 gives a ratio of 4 and N=1 gives a ratio of 8.
- R3: A power-up pulse (control bit 8) sets status bit 24 on the next clock edge when timing bit 8 is clear. When timing bit 8 is set, status bit 24 is set only after (timing bits 4:0 + 1) converter clocks. A power-down pulse (control bit 9) clears status bit 24, and triggers are then ignored.
- R4: While the interval timer runs (status bit 25), it sets the timeout flag (status bit 5) every (maximum count + 1) converter clocks. Timer start is control bit 2 and timer stop is control bit 1. A stopped timer sets no further flags.
- R5: The trigger source is selected by sequencer bits 10:8: 0 software, 1 interval timer, 3 continuous, 4 rising edge, 5 falling edge, 6 both edges. The software trigger (control bit 3) starts a conversion only when the source is 0.
- R6: With source 3, conversions start back to back, one every 8 converter clocks.
- R7: The external pin is synchronised. Source 4 converts on rising edges only, source 5 on falling edges only, and source 6 on both.
- R8: The last-result register holds the formatted sample in bits 15:0, the positive channel in bits 19:16 and the negative channel in bits 22:20. In 12-bit mode the sample is shifted left by 4 when left-adjust is set and right-aligned otherwise. In 8-bit mode (sequencer bit 12) the top 8 sample bits are placed in bits 15:8 when left-adjust is set and in bits 7:0 otherwise.
- R9: Each completed conversion sets the end-of-conversion flag (status bit 0). A completion that finds that flag still set also sets the overrun flag (status bit 1).
- R10: A trigger that arrives while the sequencer is busy sets the missed-trigger flag (status bit 3) and starts no conversion.
- R11: Writing 1 to a bit of the status-clear register clears that flag and leaves the other flags unchanged.
- R12: Writes to 0x20 set mask bits and writes to 0x24 clear them, limited to the implemented flags 0, 1, 2, 3 and 5. The mask reads back at 0x28. `irq` is high exactly when some flag and its mask bit are both set.
- R13: A soft reset (control bit 0) returns the sequencer to idle (status bits 26 and 27 low) and stops the timer. A completion still pending from the converter is then ignored, and the configuration registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | synchronous active-low reset |
| bus_wr | input | 1 | register write strobe, one cycle per write |
| bus_addr | input | 6 | register byte address |
| bus_wdata | input | 32 | register write data |
| bus_rdata | output | 32 | register read data for `bus_addr`, combinational |
| ext_trig | input | 1 | asynchronous external trigger pin |
| conv_start | output | 1 | one-cycle request to the converter cell |
| conv_pos | output | 4 | positive channel select to the cell |
| conv_neg | output | 3 | negative channel select to the cell |
| conv_done | input | 1 | one-cycle completion from the cell |
| conv_data | input | 12 | raw sample, valid with `conv_done` |
| irq | output | 1 | interrupt request |

## Verification
The assertions assume a converter cell that raises `conv_done` as a single-cycle pulse only after a `conv_start`. They also assume bus writes that last exactly one cycle. The bench stub answers every start after a programmable latency, and the bench drives every write as a one-cycle strobe away from the clock edge. The interval timer and continuous periods are measured as differences between event times, so the results do not depend on the starting phase of the prescaler. The external pin is driven only between clock edges, with each level held for several cycles so that it clears the synchroniser.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Shared constants, register indices and helper function for the ADC
// sequencer. Assumes word-aligned 32-bit register accesses.
package adc_seq_pkg;
    localparam int ADDR_W  = 6;
    localparam int REG_W   = 32;
    localparam int RAW_W   = 12;
    localparam int LV_W    = 16;
    localparam int PRESC_W = 3;
    localparam int ITMR_W  = 16;
    localparam int STUP_W  = 5;
    localparam int POS_W   = 4;
    localparam int NEG_W   = 3;
    localparam int TRG_W   = 3;
    localparam int FLAG_W  = 6;
    localparam int CONT_CYC = 8;

    localparam logic [3:0] IDX_CTRL  = 4'd0;
    localparam logic [3:0] IDX_CFG   = 4'd1;
    localparam logic [3:0] IDX_STAT  = 4'd2;
    localparam logic [3:0] IDX_CLR   = 4'd3;
    localparam logic [3:0] IDX_SEQ   = 4'd4;
    localparam logic [3:0] IDX_TIM   = 4'd5;
    localparam logic [3:0] IDX_ITMR  = 4'd6;
    localparam logic [3:0] IDX_LAST  = 4'd7;
    localparam logic [3:0] IDX_IEN   = 4'd8;
    localparam logic [3:0] IDX_IDIS  = 4'd9;
    localparam logic [3:0] IDX_IMASK = 4'd10;

    localparam logic [TRG_W-1:0] TRG_SW   = 3'd0;
    localparam logic [TRG_W-1:0] TRG_TMR  = 3'd1;
    localparam logic [TRG_W-1:0] TRG_CONT = 3'd3;
    localparam logic [TRG_W-1:0] TRG_RISE = 3'd4;
    localparam logic [TRG_W-1:0] TRG_FALL = 3'd5;
    localparam logic [TRG_W-1:0] TRG_BOTH = 3'd6;

    localparam logic [FLAG_W-1:0] FLAG_IMPL = 6'b101111;
    localparam logic [REG_W-1:0]  SEQ_IMPL  = 32'h007F_1701;

    typedef enum logic [1:0] {SQ_IDLE, SQ_CONV, SQ_STORE} seq_state_e;

    // Place a raw sample into the 16-bit result field.
    function automatic logic [LV_W-1:0] fmt_result(input logic [RAW_W-1:0] raw,
                                                  input logic narrow, input logic left);
        logic [LV_W-1:0] r;
        if (narrow)
            r = left ? {raw[RAW_W-1 -: 8], {(LV_W-8){1'b0}}} : {{(LV_W-8){1'b0}}, raw[RAW_W-1 -: 8]};
        else
            r = left ? {raw, {(LV_W-RAW_W){1'b0}}} : {{(LV_W-RAW_W){1'b0}}, raw};
        return r;
    endfunction
endpackage

// File: rtl/adc_timebase.sv
`timescale 1ns/1ps
// Power-of-two prescaler producing the converter clock enable, plus the
// reload interval timer that counts converter clocks.
// Assumes: run is high while the block is powered; presc may change live.
module adc_timebase
    import adc_seq_pkg::*;
#(
    parameter int PW = PRESC_W,
    parameter int TW = ITMR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] presc,
    input  logic          tmr_go,
    input  logic          tmr_halt,
    input  logic [TW-1:0] tmr_max,
    output logic          adc_tick,
    output logic          tmr_run,
    output logic          tmr_tto
);
    localparam int DIV_W = (1 << PW) + 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic [TW-1:0]    t_cnt;
    logic             run_q;

    assign div_last = DIV_W'((64'd1 << (32'(presc) + 32'd2)) - 64'd1);
    assign adc_tick = run && (div_cnt >= div_last);
    assign tmr_run  = run_q;
    assign tmr_tto  = run_q && adc_tick && (t_cnt == tmr_max);

    // Prescaler count, restarted whenever the block is unpowered.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            div_cnt <= '0;
        else if (div_cnt >= div_last)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    // Interval timer: reloads to zero after reaching the maximum count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tmr_halt) begin
            run_q <= 1'b0;
            t_cnt <= '0;
        end else if (tmr_go) begin
            run_q <= 1'b1;
            t_cnt <= '0;
        end else if (run_q && adc_tick) begin
            t_cnt <= (t_cnt == tmr_max) ? '0 : t_cnt + 1'b1;
        end
    end

    // R2: the smallest ratio is 4, so converter ticks never come back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        adc_tick |=> !adc_tick);
endmodule

// File: rtl/adc_trig_sel.sv
`timescale 1ns/1ps
// Trigger source selection: software pulse, interval timer, continuous
// sequencing every CYC converter clocks, or synchronised pin edges.
// Assumes: ext_pin is asynchronous; sw_req is a one-cycle pulse.
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int CYC = CONT_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TRG_W-1:0] src,
    input  logic             enabled,
    input  logic             flush,
    input  logic             sw_req,
    input  logic             tmr_tto,
    input  logic             adc_tick,
    input  logic             ext_pin,
    output logic             trig
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] C_LAST = CW'(CYC - 1);

    logic [2:0]    ext_sh;
    logic [CW-1:0] cont_cnt;
    logic          rise, fall, cont_fire, pick;

    assign rise      = ext_sh[1] & ~ext_sh[2];
    assign fall      = ~ext_sh[1] & ext_sh[2];
    assign cont_fire = adc_tick && (cont_cnt == C_LAST);

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[1:0], ext_pin};
    end

    // Continuous-mode cadence counter in converter clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !enabled || flush || src != TRG_CONT)
            cont_cnt <= '0;
        else if (adc_tick)
            cont_cnt <= (cont_cnt == C_LAST) ? '0 : cont_cnt + 1'b1;
    end

    // Source multiplexer.
    always_comb begin
        case (src)
            TRG_SW:   pick = sw_req;
            TRG_TMR:  pick = tmr_tto;
            TRG_CONT: pick = cont_fire;
            TRG_RISE: pick = rise;
            TRG_FALL: pick = fall;
            TRG_BOTH: pick = rise | fall;
            default:  pick = 1'b0;
        endcase
    end

    assign trig = enabled && !flush && pick;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// ADC sequencer and trigger controller top: register file, power-up with
// startup delay, conversion sequencer, event flags and interrupt.
// Assumes: conv_done pulses one cycle, only after conv_start; writes last
// one cycle; reads are combinational on bus_addr.
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ext_trig,
    output logic              conv_start,
    output logic [POS_W-1:0]  conv_pos,
    output logic [NEG_W-1:0]  conv_neg,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  conv_data,
    output logic              irq
);
    logic [3:0]        widx;
    logic              wr_ok, ctl_wr, clr_wr;
    logic              p_rst, p_tstop, p_tstart, p_strig, p_en, p_dis;
    logic [PRESC_W-1:0] presc_q;
    logic [REG_W-1:0]  seq_q;
    logic              tim_en_q;
    logic [STUP_W-1:0] tim_val_q, stup_cnt;
    logic [ITMR_W-1:0] itmr_q;
    logic [LV_W-1:0]   lv_val_q;
    logic [POS_W-1:0]  lv_pos_q;
    logic [NEG_W-1:0]  lv_neg_q;
    logic [FLAG_W-1:0] flags_q, mask_q, flag_set, flag_clr;
    logic              en_q, stup_q, start_q;
    logic              adc_tick, tmr_run, tmr_tto, trig;
    seq_state_e        seq_q_st;

    assign widx     = bus_addr[ADDR_W-1:2];
    assign wr_ok    = bus_wr && (bus_addr[1:0] == 2'b00);
    assign ctl_wr   = wr_ok && widx == IDX_CTRL;
    assign clr_wr   = wr_ok && widx == IDX_CLR;
    assign p_rst    = ctl_wr && bus_wdata[0];
    assign p_tstop  = ctl_wr && bus_wdata[1];
    assign p_tstart = ctl_wr && bus_wdata[2];
    assign p_strig  = ctl_wr && bus_wdata[3];
    assign p_en     = ctl_wr && bus_wdata[8];
    assign p_dis    = ctl_wr && bus_wdata[9];

    adc_timebase #(.PW(PRESC_W), .TW(ITMR_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(en_q | stup_q), .presc(presc_q),
        .tmr_go(p_tstart & en_q), .tmr_halt(p_tstop | p_rst | p_dis),
        .tmr_max(itmr_q), .adc_tick(adc_tick), .tmr_run(tmr_run), .tmr_tto(tmr_tto)
    );

    adc_trig_sel #(.CYC(CONT_CYC)) u_trig (
        .clk(clk), .rst_n(rst_n), .src(seq_q[10:8]), .enabled(en_q), .flush(p_rst),
        .sw_req(p_strig), .tmr_tto(tmr_tto), .adc_tick(adc_tick), .ext_pin(ext_trig),
        .trig(trig)
    );

    // Configuration registers; soft reset leaves them intact.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0; seq_q <= '0; tim_en_q <= 1'b0; tim_val_q <= '0;
            itmr_q <= '0; mask_q <= '0;
        end else if (wr_ok) begin
            case (widx)
                IDX_CFG:  presc_q <= bus_wdata[8 +: PRESC_W];
                IDX_SEQ:  seq_q <= bus_wdata & SEQ_IMPL;
                IDX_TIM:  begin tim_en_q <= bus_wdata[8]; tim_val_q <= bus_wdata[STUP_W-1:0]; end
                IDX_ITMR: itmr_q <= bus_wdata[ITMR_W-1:0];
                IDX_IEN:  mask_q <= mask_q | (bus_wdata[FLAG_W-1:0] & FLAG_IMPL);
                IDX_IDIS: mask_q <= mask_q & ~bus_wdata[FLAG_W-1:0];
                default:  ;
            endcase
        end
    end

    // Power-up sequencing with optional startup delay in converter clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || p_dis) begin
            en_q <= 1'b0; stup_q <= 1'b0; stup_cnt <= '0;
        end else if (p_en && !en_q && !stup_q) begin
            if (tim_en_q) begin stup_q <= 1'b1; stup_cnt <= tim_val_q; end
            else          en_q <= 1'b1;
        end else if (stup_q && adc_tick) begin
            if (stup_cnt == '0) begin stup_q <= 1'b0; en_q <= 1'b1; end
            else                stup_cnt <= stup_cnt - 1'b1;
        end
    end

    // Conversion sequencer: issue start, wait for completion, store.
    always_ff @(posedge clk) begin
        if (!rst_n || p_rst || !en_q) begin
            seq_q_st <= SQ_IDLE; start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (seq_q_st)
                SQ_IDLE:  if (trig) begin seq_q_st <= SQ_CONV; start_q <= 1'b1; end
                SQ_CONV:  if (conv_done) seq_q_st <= SQ_STORE;
                default:  seq_q_st <= SQ_IDLE;
            endcase
        end
    end

    // Result capture with the channel numbers in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv_val_q <= '0; lv_pos_q <= '0; lv_neg_q <= '0;
        end else if (seq_q_st == SQ_CONV && conv_done && en_q && !p_rst) begin
            lv_val_q <= fmt_result(conv_data, seq_q[12], seq_q[0]);
            lv_pos_q <= seq_q[19:16];
            lv_neg_q <= seq_q[22:20];
        end
    end

    always_comb begin
        flag_set    = '0;
        flag_set[0] = (seq_q_st == SQ_STORE);
        flag_set[1] = (seq_q_st == SQ_STORE) && flags_q[0];
        flag_set[3] = trig && (seq_q_st != SQ_IDLE);
        flag_set[5] = tmr_tto;
        flag_clr    = clr_wr ? bus_wdata[FLAG_W-1:0] : '0;
    end

    // Event flags: write-one-to-clear, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= ((flags_q & ~flag_clr) | flag_set) & FLAG_IMPL;
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (widx)
            IDX_CFG:   bus_rdata[8 +: PRESC_W] = presc_q;
            IDX_STAT:  begin
                bus_rdata[FLAG_W-1:0] = flags_q;
                bus_rdata[24] = en_q;
                bus_rdata[25] = tmr_run;
                bus_rdata[26] = (seq_q_st != SQ_IDLE);
                bus_rdata[27] = (seq_q_st == SQ_CONV);
            end
            IDX_SEQ:   bus_rdata = seq_q;
            IDX_TIM:   begin bus_rdata[8] = tim_en_q; bus_rdata[STUP_W-1:0] = tim_val_q; end
            IDX_ITMR:  bus_rdata[ITMR_W-1:0] = itmr_q;
            IDX_LAST:  bus_rdata[22:0] = {lv_neg_q, lv_pos_q, lv_val_q};
            IDX_IMASK: bus_rdata[FLAG_W-1:0] = mask_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign conv_start = start_q;
    assign conv_pos   = seq_q[19:16];
    assign conv_neg   = seq_q[22:20];
    assign irq        = |(flags_q & mask_q);

    // R3: status enable appears only from the startup phase or a direct power-up
    a_r3_en_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> ($past(stup_q) || $past(p_en)));
    // R4: a timeout flag only appears while the interval timer runs
    a_r4_tto_from_timer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[5]) |-> $past(tmr_run));
    // R9: a completion over an uncleared end-of-conversion flags overrun
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q_st == SQ_STORE && flags_q[0] && !(clr_wr && bus_wdata[1])) |=> flags_q[1]);
    // R10: a trigger into a busy sequencer is recorded as missed
    a_r10_missed: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && seq_q_st != SQ_IDLE && !(clr_wr && bus_wdata[3])) |=> flags_q[3]);
    // R13: soft reset leaves the sequencer idle
    a_r13_idle_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
        p_rst |=> (seq_q_st == SQ_IDLE && !conv_start));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, ext_trig = 1'b0, conv_done = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [11:0] conv_data = '0;
    logic        conv_start, irq;
    logic [3:0]  conv_pos;
    logic [2:0]  conv_neg;

    localparam logic [5:0] A_CTRL = 6'h00, A_CFG = 6'h04, A_STAT = 6'h08, A_CLR = 6'h0C,
                           A_SEQ = 6'h10, A_TIM = 6'h14, A_ITMR = 6'h18, A_LAST = 6'h1C,
                           A_IEN = 6'h20, A_IDIS = 6'h24, A_IMASK = 6'h28;
    // {raw sample, 8-bit mode, left-adjust, expected 16-bit result}
    localparam logic [29:0] VEC [8] = '{
        {12'hABC, 1'b0, 1'b1, 16'hABC0}, {12'hABC, 1'b0, 1'b0, 16'h0ABC},
        {12'hABC, 1'b1, 1'b1, 16'hAB00}, {12'hABC, 1'b1, 1'b0, 16'h00AB},
        {12'hFFF, 1'b0, 1'b1, 16'hFFF0}, {12'h001, 1'b0, 1'b1, 16'h0010},
        {12'h001, 1'b1, 1'b0, 16'h0000}, {12'h80F, 1'b1, 1'b1, 16'h8000}};

    int n_chk = 0, n_bad = 0, cyc = 0;
    int stub_lat = 2, stub_left = 0, n_start = 0, t_prev = 0, t_last = 0;
    logic [11:0] stub_val = '0;
    bit finished = 0;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_trig(ext_trig), .conv_start(conv_start), .conv_pos(conv_pos),
        .conv_neg(conv_neg), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    // Converter stub: answers each start after stub_lat cycles.
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (stub_left > 0) begin
            stub_left--;
            if (stub_left == 0) begin conv_done = 1'b1; conv_data = stub_val; end
        end
        if (conv_start) begin n_start++; t_prev = t_last; t_last = cyc; stub_left = stub_lat; end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0; bus_wdata = '0;
    endtask
    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_wr = 1'b0; bus_addr = a; #1 d = bus_rdata;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask
    // Period in cycles between the 2nd and 3rd timeout flags seen.
    task automatic measure(output int period);
        logic [31:0] d; int seen = 0, t1 = 0;
        period = -1;
        wr(A_CLR, 32'h20);
        for (int k = 0; k < 3000 && seen < 3; k++) begin
            rd(A_STAT, d);
            if (d[5]) begin
                seen++;
                if (seen == 2) t1 = cyc;
                if (seen == 3) period = cyc - t1;
                wr(A_CLR, 32'h20);
            end
        end
    endtask
    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d; int n0, per;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, d);  chk("R1 status", d, 0);
        rd(A_IMASK, d); chk("R1 mask", d, 0);
        rd(A_LAST, d);  chk("R1 last", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 conv_start", {31'd0, conv_start}, 0);

        // R3 power-up without startup delay
        wr(A_TIM, 0); wr(A_CTRL, 32'h100);
        rd(A_STAT, d); chk("R3 enabled at once", {31'd0, d[24]}, 1);

        // R8 vector table walk: formatting and channel fields
        for (int i = 0; i < 8; i++) begin
            logic [29:0] v; v = VEC[i];
            wr(A_SEQ, (32'(7 - i) << 20) | (32'(i) << 16) | (32'(v[17]) << 12) | 32'(v[16]));
            stub_val = v[29:18];
            wr(A_CTRL, 32'h8); idle(10);
            rd(A_LAST, d);
            chk("R8 result", d, {9'd0, 3'(7 - i), 4'(i), v[15:0]});
            wr(A_CLR, 32'h2F);
        end

        // R9 end-of-conversion then overrun; R11 selective clear
        stub_val = 12'h123;
        wr(A_CTRL, 32'h8); idle(10); rd(A_STAT, d); chk("R9 eoc only", d[1:0], 2'b01);
        wr(A_CTRL, 32'h8); idle(10); rd(A_STAT, d); chk("R9 overrun", d[1:0], 2'b11);
        wr(A_CLR, 32'h1); rd(A_STAT, d); chk("R11 clear eoc keeps ovr", d[1:0], 2'b10);
        wr(A_CLR, 32'h2); rd(A_STAT, d); chk("R11 clear ovr", d[5:0], 0);

        // R12 mask set/clear, readback, irq
        wr(A_IEN, 32'h3F); rd(A_IMASK, d); chk("R12 mask implemented bits", d, 32'h2F);
        chk("R12 irq idle", {31'd0, irq}, 0);
        wr(A_CTRL, 32'h8); idle(10); rd(A_STAT, d);
        chk("R12 irq on eoc", {31'd0, irq}, 1);
        wr(A_IDIS, 32'h3F); rd(A_IMASK, d); chk("R12 mask cleared", d, 0);
        chk("R12 irq masked", {31'd0, irq}, 0);
        wr(A_CLR, 32'h2F);

        // R10 missed trigger while busy
        stub_lat = 30; n0 = n_start;
        wr(A_CTRL, 32'h8); idle(2); wr(A_CTRL, 32'h8); idle(40);
        rd(A_STAT, d); chk("R10 missed flag", {31'd0, d[3]}, 1);
        chk("R10 single start", n_start - n0, 1);
        wr(A_CLR, 32'h2F);

        // R13 soft reset mid-conversion
        stub_lat = 40; wr(A_SEQ, 32'h0035_0001);
        wr(A_CTRL, 32'h8); idle(3);
        rd(A_STAT, d); chk("R13 busy before", {30'd0, d[27:26]}, 3);
        wr(A_CTRL, 32'h1);
        rd(A_STAT, d); chk("R13 idle after", {30'd0, d[27:26]}, 0);
        idle(50);
        rd(A_STAT, d); chk("R13 late completion ignored", {31'd0, d[0]}, 0);
        rd(A_SEQ, d); chk("R13 config kept", d, 32'h0035_0001);
        stub_lat = 2;

        // R2 and R4 interval timer period with two ratios
        wr(A_SEQ, 0); wr(A_CFG, 32'h000); wr(A_ITMR, 9);
        wr(A_CTRL, 32'h4); rd(A_STAT, d); chk("R4 timer running", {31'd0, d[25]}, 1);
        measure(per); chk("R2 ratio 4 period", per, 40);
        wr(A_CTRL, 32'h2); wr(A_CFG, 32'h100); wr(A_CTRL, 32'h4);
        measure(per); chk("R2 ratio 8 period", per, 80);
        wr(A_CTRL, 32'h2); rd(A_STAT, d); chk("R4 timer stopped", {31'd0, d[25]}, 0);
        wr(A_CLR, 32'h2F); idle(100);
        rd(A_STAT, d); chk("R4 no timeout when stopped", {31'd0, d[5]}, 0);

        // R5 interval timer as trigger source
        wr(A_CFG, 0); wr(A_SEQ, 32'h100); n0 = n_start;
        wr(A_CTRL, 32'h4); idle(200);
        chk("R5 timer triggers", {31'd0, (n_start - n0) >= 4}, 1);
        wr(A_CTRL, 32'h2);

        // R6 continuous back-to-back cadence
        wr(A_SEQ, 32'h300); idle(150);
        chk("R6 continuous spacing", t_last - t_prev, 32);
        wr(A_SEQ, 0); idle(20); wr(A_CLR, 32'h2F);

        // R7 edge modes; R5 software trigger ignored outside software mode
        wr(A_SEQ, 32'h400); n0 = n_start;
        @(negedge clk) ext_trig = 1'b1; idle(8); chk("R7 rising converts", n_start - n0, 1);
        @(negedge clk) ext_trig = 1'b0; idle(8); chk("R7 falling ignored in rise mode", n_start - n0, 1);
        wr(A_SEQ, 32'h500); n0 = n_start;
        wr(A_CTRL, 32'h8); idle(10); chk("R5 sw trigger ignored", n_start - n0, 0);
        @(negedge clk) ext_trig = 1'b1; idle(8); chk("R7 rising ignored in fall mode", n_start - n0, 0);
        @(negedge clk) ext_trig = 1'b0; idle(8); chk("R7 falling converts", n_start - n0, 1);
        wr(A_SEQ, 32'h600); n0 = n_start;
        @(negedge clk) ext_trig = 1'b1; idle(8);
        @(negedge clk) ext_trig = 1'b0; idle(8); chk("R7 both edges", n_start - n0, 2);

        // R3 power-down ignores triggers, then startup delay
        wr(A_SEQ, 0); wr(A_CTRL, 32'h200);
        rd(A_STAT, d); chk("R3 disabled", {31'd0, d[24]}, 0);
        n0 = n_start; wr(A_CTRL, 32'h8); idle(10); chk("R3 trigger ignored when off", n_start - n0, 0);
        wr(A_CFG, 0); wr(A_TIM, 32'h103); wr(A_CTRL, 32'h100);
        idle(9); rd(A_STAT, d); chk("R3 not yet enabled", {31'd0, d[24]}, 0);
        idle(8); rd(A_STAT, d); chk("R3 enabled after startup", {31'd0, d[24]}, 1);

        summary();
        finished = 1;
        $finish;
    end
endmodule